// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Control Register

This block holds the control word a four-processor system uses for timer-tick and interprocessor interrupts. A periodic tick pulse flags a timer interrupt for every processor that has no flag pending. Each flag drives that processor's timer interrupt line until software writes a one to the matching bit to clear it. Software on any processor raises an interprocessor interrupt on a target by writing a one to the target's request bit. The target acknowledges by writing a one to its clear bit.

Every processor keeps a saturating pending count of interprocessor requests, so its line stays high until it has seen as many clears as sends. A read returns the stored flags with the reading processor's number in the two lowest bits. A write that touches none of the control fields produces a one-cycle error pulse and changes nothing.

Top module: `misc_intr_ctrl`

## Requirements
- R1: A read with rd_en_i high returns the timer flags in bits 7:4 (CPU i at bit 4+i), the interprocessor flags in bits 11:8 (CPU i at bit 8+i), and rd_cpu_i in bits 1:0. Every other bit reads zero. With rd_en_i low the read data is zero.
- R2: A tick sets the timer flag of every CPU. From the next cycle each timer_irq_o bit is high.
- R3: A write with a 1 in bit 4+i clears CPU i's timer flag and line from the next cycle.
- R4: A tick in the same cycle as a write that clears CPU i's timer flag leaves that flag set.
- R5: A write with a 1 in bit 12+i sets flag bit 8+i, adds one to CPU i's pending count and raises ipi_irq_o[i] from the next cycle.
- R6: A write with a 1 in bit 8+i clears flag bit 8+i and takes one from CPU i's pending count if it is nonzero. ipi_irq_o[i] is high exactly while the count is nonzero.
- R7: Within one write the timer clear field acts first, then the request field (bits 15:12), then the interprocessor clear field (bits 11:8). Request and clear together for one CPU end with its flag clear and its count unchanged, unless the count is saturated.
- R8: Each pending count is 4 bits and holds at 15 instead of wrapping. After 16 requests, the 15th clear drops the line.
- R9: A write with bits 15:4 all zero raises wr_err_o for exactly the next cycle and changes no flag or count.
- R10: After reset all flags, counts, interrupt lines and wr_err_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer tick pulse, one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_cpu_i | input | 2 | Number of the reading CPU |
| rd_data_o | output | 64 | Read data, combinational |
| timer_irq_o | output | 4 | Timer interrupt line per CPU |
| ipi_irq_o | output | 4 | Interprocessor interrupt line per CPU |
| wr_err_o | output | 1 | Unsupported write pulse |

## Verification
The assertions assume that wr_en_i and tick_i are known at every clock edge after reset, that tick_i is a pulse, and that rd_cpu_i is stable while rd_en_i is high. The bench drives every input at the falling edge. It holds tick_i high for exactly one cycle at a time. It changes rd_cpu_i only between samples. A software model of flags and counts predicts every output after each cycle. The bench sweeps all 4096 values of the control fields with ticks interleaved, which drives the counts into and out of saturation.

// File: rtl/misc_intr_pkg.sv
package misc_intr_pkg;
  localparam int unsigned TFLAG_LSB = 4;   // timer flags / timer clear
  localparam int unsigned ICLR_LSB  = 8;   // ipi flags / ipi clear
  localparam int unsigned IREQ_LSB  = 12;  // ipi request
  localparam int unsigned FIELD_MSB = 15;
endpackage

// File: rtl/misc_timer_flag.sv
module misc_timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (tick_i) flag_o <= 1'b1;  // tick wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_tick_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> flag_o);
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> !flag_o);
endmodule

// File: rtl/misc_ipi_slot.sv
module misc_ipi_slot #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;

  // request applied before clear
  always_comb begin
    cnt_inc = (req_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
    cnt_d   = (clr_i && cnt_inc != '0) ? cnt_inc - 1'b1 : cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (clr_i)      flag_o <= 1'b0;
      else if (req_i) flag_o <= 1'b1;
    end
  end

  assign irq_o = (cnt_q != '0);

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && req_i && !clr_i) |=> cnt_q == CNT_MAX);
  assert_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !req_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_req_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !clr_i) |=> (irq_o && flag_o));
  assert_both_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && clr_i && cnt_q != CNT_MAX) |=> (!flag_o && $stable(cnt_q)));
endmodule

// File: rtl/misc_intr_ctrl.sv
module misc_intr_ctrl
  import misc_intr_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    wr_en_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    rd_en_i,
  input  logic [$clog2(NCPU)-1:0] rd_cpu_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [NCPU-1:0]         timer_irq_o,
  output logic [NCPU-1:0]         ipi_irq_o,
  output logic                    wr_err_o
);
  localparam int unsigned ID_W = $clog2(NCPU);

  logic [NCPU-1:0] tclr, ireq, iclr, tflag, iflag;
  logic            ctl_hit, bad_wr;

  assign ctl_hit = |wr_data_i[FIELD_MSB:TFLAG_LSB];
  assign bad_wr  = wr_en_i && !ctl_hit;
  assign tclr    = wr_en_i ? wr_data_i[TFLAG_LSB +: NCPU] : '0;
  assign ireq    = wr_en_i ? wr_data_i[IREQ_LSB  +: NCPU] : '0;
  assign iclr    = wr_en_i ? wr_data_i[ICLR_LSB  +: NCPU] : '0;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    misc_timer_flag u_tflag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .clr_i  (tclr[i]),
      .flag_o (tflag[i])
    );
    misc_ipi_slot #(.CNT_W(CNT_W)) u_ipi (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (ireq[i]),
      .clr_i  (iclr[i]),
      .flag_o (iflag[i]),
      .irq_o  (ipi_irq_o[i])
    );
  end

  assign timer_irq_o = tflag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_err_o <= 1'b0;
    else         wr_err_o <= bad_wr;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      rd_data_o[ID_W-1:0]            = rd_cpu_i;
      rd_data_o[TFLAG_LSB +: NCPU]   = tflag;
      rd_data_o[ICLR_LSB  +: NCPU]   = iflag;
    end
  end

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> wr_err_o);
  assert_err_nochange_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_wr && !tick_i) |=> ($stable(tflag) && $stable(iflag) && $stable(ipi_irq_o)));
  assert_tick_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (&timer_irq_o));
endmodule

// File: tb/misc_intr_ctrl_tb.sv
module misc_intr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tick_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [63:0] wr_data_i = '0;
  logic [1:0]  rd_cpu_i = '0;
  logic [63:0] rd_data_o;
  logic [3:0]  timer_irq_o, ipi_irq_o;
  logic        wr_err_o;

  int errors = 0, checks = 0;
  logic [3:0] m_t, m_i;
  int m_cnt [4];
  logic m_err;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  misc_intr_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_cpu_i(rd_cpu_i),
    .rd_data_o(rd_data_o), .timer_irq_o(timer_irq_o), .ipi_irq_o(ipi_irq_o),
    .wr_err_o(wr_err_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [3:0] exp_ipi;
    for (int c = 0; c < NCPU; c++) begin
      rd_cpu_i = c[1:0];
      rd_en_i  = 1'b1;
      #1;
      chk({tag, " R1 read"}, rd_data_o,
          {48'd0, 4'd0, m_i, m_t, 2'd0, c[1:0]});
    end
    rd_en_i = 1'b0;
    #1;
    chk({tag, " R1 idle"}, rd_data_o, 64'd0);
    for (int c = 0; c < NCPU; c++) exp_ipi[c] = (m_cnt[c] != 0);
    chk({tag, " timer"}, {60'd0, timer_irq_o}, {60'd0, m_t});
    chk({tag, " ipi"}, {60'd0, ipi_irq_o}, {60'd0, exp_ipi});
    chk({tag, " err"}, {63'd0, wr_err_o}, {63'd0, m_err});
  endtask

  task automatic step(logic tk, logic we, logic [63:0] d, string tag);
    @(negedge clk_i);
    tick_i = tk; wr_en_i = we; wr_data_i = d;
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    tick_i = 0; wr_en_i = 0; wr_data_i = '0;
    m_err = we && (d[15:4] == 12'd0);
    if (we && !m_err) begin
      for (int c = 0; c < NCPU; c++) begin
        if (d[4+c]) m_t[c] = 1'b0;
        if (d[12+c]) begin m_i[c] = 1'b1; if (m_cnt[c] < 15) m_cnt[c]++; end
        if (d[8+c])  begin m_i[c] = 1'b0; if (m_cnt[c] > 0)  m_cnt[c]--; end
      end
    end
    if (tk) m_t = 4'hf;
    check_all(tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD*150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_t = 0; m_i = 0; m_err = 0;
    for (int c = 0; c < NCPU; c++) m_cnt[c] = 0;
    #(CLK_PERIOD*3);
    check_all("R10 in reset");
    rst_ni = 1'b1;
    step(0, 0, 0, "R10 after reset");
    step(1, 0, 0, "R2 tick");
    for (int c = 0; c < NCPU; c++) step(0, 1, 64'd1 << (4+c), "R3 clear timer");
    step(1, 0, 0, "R2 tick again");
    step(1, 1, 64'h00f0, "R4 tick vs clear");
    step(0, 1, 64'h0030, "R3 partial clear");
    for (int c = 0; c < NCPU; c++) step(0, 1, 64'd1 << (12+c), "R5 request");
    step(0, 1, 64'h1000, "R5 second request");
    step(0, 1, 64'h0100, "R6 clear keeps line");
    step(0, 1, 64'h0100, "R6 clear drops line");
    step(0, 1, 64'h0100, "R6 clear at zero");
    step(0, 1, 64'h2200, "R7 req and clear same cpu");
    step(0, 1, 64'h4020, "R7 mixed fields");
    step(0, 1, 64'hffff_0000_0000_000f, "R9 unsupported write");
    step(0, 0, 0, "R9 pulse ends");
    for (int n = 0; n < 16; n++) step(0, 1, 64'h8000, "R8 saturate");
    for (int n = 0; n < 15; n++) step(0, 1, 64'h0800, "R8 drain");
    // near-exhaustive sweep of control fields
    for (int v = 0; v < 4096; v++)
      step((v % 7) == 3, 1'b1, {48'd0, v[11:0], 4'h5}, "R7 sweep");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule